// File: doc/BRIEF.md
# DMA Channel Transfer Engine

This block is the transfer state machine of a single DMA channel. Software, or a surrounding register file, programs five channel words: source address, destination address, link pointer, control and configuration. It then pulses `kick`. The engine checks whether the channel may run. This needs the enable bit, a clear halt bit, a supported flow mode with the peripheral requests it calls for, and a nonzero element count. While the channel may run, the engine moves elements one at a time over a simple request/ready memory master port. Each element is one read followed by one write.

After each element the engine decrements the count and advances the addresses that have increment enabled. It then looks at the same channel again at once. When the count reaches zero, one of two things happens. If the link pointer is nonzero, the engine fetches a four-word descriptor and carries on with it. If the link pointer is zero, it clears the channel's enable bit. A one-cycle terminal-count pulse marks each completion whose control word requests it.

Channel words can be written only while the engine is idle. Their current values are visible at all times on the `*_q` outputs.

Top module: `dma_chan_engine`

## Requirements
- R1: The engine starts an element only when configuration bit 0 (enable) is 1 and configuration bit 18 (halt) is 0. Otherwise a kick produces no memory access and leaves the channel words unchanged.
- R2: The flow mode is configuration bits 13:11. The source peripheral number is bits 5:1 and the destination peripheral number is bits 10:6. The request vector is `req_single | req_burst`. Mode 0 always proceeds. Mode 1 needs the destination's request bit. Mode 2 needs the source's request bit. Mode 3 needs both bits. Modes 4 to 7 never transfer.
- R3: The element count is control bits 11:0. When the count is zero, the engine makes no access and the enable bit stays set.
- R4: Each element is one read at the source address with `mem_size` equal to control bits 20:18. It is followed by one write of the read data at the destination address with `mem_size` equal to control bits 23:21. Afterwards the count drops by one and control bits 31:12 are unchanged.
- R5: After each element the source address grows by 2^(control 20:18) if control bit 26 is set. The destination address grows by 2^(control 23:21) if control bit 27 is set. A cleared increment bit leaves its address unchanged.
- R6: A single kick moves every remaining element of the channel, one after another, as long as the channel stays eligible.
- R7: When the count reaches zero and the link pointer is zero, configuration bit 0 is cleared and all other configuration bits are kept.
- R8: When the count reaches zero and the link pointer L is nonzero, four word reads (`mem_size` 2) follow. They are made at L, L+4, L+12 and L+8, in that order, and load source, destination, control and link pointer respectively. Transfers then continue with the new descriptor.
- R9: On each completion (count reaching zero), `tc_pulse` is high for exactly one cycle if bit 31 of the control word active after that completion is set. After a link fetch, this is the newly loaded word.
- R10: A memory request holds `mem_req`, `mem_we` and `mem_addr` steady until `mem_ready` is seen.
- R11: While `glb_en` is low, a kick is ignored: `busy` stays low and no access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Global controller enable |
| kick | input | 1 | Request to evaluate the channel |
| reg_we | input | 1 | Channel word write strobe (taken only when idle) |
| reg_addr | input | 3 | Word select: 0 source, 1 destination, 2 link, 3 control, 4 configuration |
| reg_wdata | input | 32 | Channel word write data |
| req_single | input | 32 | Single-transfer request lines per peripheral |
| req_burst | input | 32 | Burst request lines per peripheral |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Byte address of the access |
| mem_size | output | 3 | log2 of access width in bytes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes in this cycle |
| tc_pulse | output | 1 | Terminal-count pulse |
| busy | output | 1 | Engine is not idle |
| src_q | output | AW | Current source address |
| dst_q | output | AW | Current destination address |
| link_q | output | AW | Current link pointer |
| ctl_q | output | 32 | Current control word |
| cfg_q | output | 32 | Current configuration word |

## Verification
The bench sweeps every flow mode against all four combinations of source and destination requests. The source request arrives on one request vector and the destination request on the other, so an engine that ignored either vector, or swapped the peripheral fields, would move data when it should not. A descriptor chain is read back through the access log: fetching the control word from L+8 instead of L+12, or raising the terminal count from the old control word, shows up directly. Counts of zero, halt, disabled channels and mixed element widths catch an engine that reads before checking the count, clears the enable bit too early, or steps the destination by the source width. Random-delay ready responses with randomized counts, widths and increment settings check the final addresses, the access count and the terminal-count pulses.

// File: rtl/dma_chan_engine.sv
module dma_chan_engine #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          glb_en,
  input  logic          kick,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  input  logic [31:0]   req_single,
  input  logic [31:0]   req_burst,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [2:0]    mem_size,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ready,
  output logic          tc_pulse,
  output logic          busy,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [AW-1:0] link_q,
  output logic [31:0]   ctl_q,
  output logic [31:0]   cfg_q
);

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_READ, S_WRITE, S_UPDATE,
    S_LINK0, S_LINK1, S_LINK2, S_LINK3, S_DONE
  } state_t;

  state_t      state;
  logic        pend;
  logic [31:0] buf_q;
  logic        flow_ok;

  wire [31:0]   req_v    = req_single | req_burst;
  wire [2:0]    flow     = cfg_q[13:11];
  wire [4:0]    sper     = cfg_q[5:1];
  wire [4:0]    dper     = cfg_q[10:6];
  wire [11:0]   cnt      = ctl_q[11:0];
  wire [11:0]   cnt_nx   = cnt - 12'd1;
  wire [AW-1:0] sstep    = AW'(1) << ctl_q[20:18];
  wire [AW-1:0] dstep    = AW'(1) << ctl_q[23:21];
  wire          link_st  = (state == S_LINK0) || (state == S_LINK1) ||
                           (state == S_LINK2) || (state == S_LINK3);
  wire          go       = glb_en && cfg_q[0] && !cfg_q[18] && flow_ok && (cnt != 12'd0);

  always_comb begin
    case (flow)
      3'd0:    flow_ok = 1'b1;
      3'd1:    flow_ok = req_v[dper];
      3'd2:    flow_ok = req_v[sper];
      3'd3:    flow_ok = req_v[sper] && req_v[dper];
      default: flow_ok = 1'b0;
    endcase
  end

  assign busy      = (state != S_IDLE);
  assign mem_req   = (state == S_READ) || (state == S_WRITE) || link_st;
  assign mem_we    = (state == S_WRITE);
  assign mem_wdata = buf_q;
  assign mem_size  = (state == S_READ)  ? ctl_q[20:18] :
                     (state == S_WRITE) ? ctl_q[23:21] : 3'd2;

  always_comb begin
    case (state)
      S_READ:  mem_addr = src_q;
      S_WRITE: mem_addr = dst_q;
      S_LINK0: mem_addr = link_q;
      S_LINK1: mem_addr = link_q + AW'(4);
      S_LINK2: mem_addr = link_q + AW'(12);
      S_LINK3: mem_addr = link_q + AW'(8);
      default: mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      pend     <= 1'b0;
      buf_q    <= '0;
      tc_pulse <= 1'b0;
      src_q    <= '0;
      dst_q    <= '0;
      link_q   <= '0;
      ctl_q    <= '0;
      cfg_q    <= '0;
    end else begin
      tc_pulse <= 1'b0;
      if (state != S_IDLE && kick && glb_en) pend <= 1'b1;
      case (state)
        S_IDLE: begin
          if (reg_we) begin
            case (reg_addr)
              3'd0:    src_q  <= reg_wdata[AW-1:0];
              3'd1:    dst_q  <= reg_wdata[AW-1:0];
              3'd2:    link_q <= reg_wdata[AW-1:0];
              3'd3:    ctl_q  <= reg_wdata;
              3'd4:    cfg_q  <= reg_wdata;
              default: ;
            endcase
          end
          if (glb_en && (kick || pend)) begin
            state <= S_CHECK;
            pend  <= 1'b0;
          end
        end
        S_CHECK: state <= go ? S_READ : S_DONE;
        S_READ: if (mem_ready) begin
          buf_q <= mem_rdata;
          state <= S_WRITE;
        end
        S_WRITE: if (mem_ready) state <= S_UPDATE;
        S_UPDATE: begin
          if (ctl_q[26]) src_q <= src_q + sstep;
          if (ctl_q[27]) dst_q <= dst_q + dstep;
          ctl_q[11:0] <= cnt_nx;
          if (cnt_nx != 12'd0) begin
            state <= S_CHECK;
          end else if (link_q != '0) begin
            state <= S_LINK0;
          end else begin
            cfg_q[0] <= 1'b0;
            tc_pulse <= ctl_q[31];
            state    <= S_CHECK;
          end
        end
        S_LINK0: if (mem_ready) begin src_q <= mem_rdata[AW-1:0]; state <= S_LINK1; end
        S_LINK1: if (mem_ready) begin dst_q <= mem_rdata[AW-1:0]; state <= S_LINK2; end
        S_LINK2: if (mem_ready) begin ctl_q <= mem_rdata;         state <= S_LINK3; end
        S_LINK3: if (mem_ready) begin
          link_q   <= mem_rdata[AW-1:0];
          tc_pulse <= ctl_q[31];
          state    <= S_CHECK;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10
  a_r10_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R4
  a_r4_count_dec: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_UPDATE |=> ctl_q[11:0] == $past(ctl_q[11:0]) - 12'd1 &&
                          ctl_q[31:12] == $past(ctl_q[31:12]));

  // R11
  a_r11_gate_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_CHECK && !glb_en |=> !mem_req);

  // R1
  a_r1_halt_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_CHECK && cfg_q[18] |=> !mem_req);

  // R9
  a_r9_tc_single: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |=> !tc_pulse);

endmodule

// File: tb/dma_chan_engine_test.sv
module dma_chan_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        glb_en = 1'b0;
  logic        kick = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] req_single = '0;
  logic [31:0] req_burst = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [2:0]  mem_size;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;
  logic        tc_pulse, busy;
  logic [31:0] src_q, dst_q, link_q, ctl_q, cfg_q;

  dma_chan_engine #(.AW(32)) uut (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .kick(kick),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .req_single(req_single), .req_burst(req_burst),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .tc_pulse(tc_pulse), .busy(busy),
    .src_q(src_q), .dst_q(dst_q), .link_q(link_q), .ctl_q(ctl_q), .cfg_q(cfg_q));

  always #2 clk = ~clk;

  logic [31:0] mem [0:255];
  logic [31:0] lg_addr [0:63];
  logic        lg_we   [0:63];
  logic [2:0]  lg_size [0:63];
  int nlog = 0;
  int tc_cnt = 0;
  int nchk = 0;
  int nfail = 0;
  bit finished = 0;
  int wait_cnt = 0;

  initial forever begin
    @(negedge clk);
    if (mem_ready) mem_ready = 1'b0;
    else if (mem_req) begin
      if (wait_cnt == 0) begin
        if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
        else mem_rdata = mem[mem_addr[9:2]];
        if (nlog < 64) begin
          lg_addr[nlog] = mem_addr; lg_we[nlog] = mem_we; lg_size[nlog] = mem_size;
        end
        nlog++;
        mem_ready = 1'b1;
        wait_cnt = $urandom % 3;
      end else wait_cnt--;
    end
  end

  always @(negedge clk) if (tc_pulse) tc_cnt++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic run();
    nlog = 0; tc_cnt = 0;
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] mk_ctl(int cnt, int ss, int ds, bit si, bit di, bit ie);
    return {ie, 3'b0, di, si, 2'b0, 3'(ds), 3'(ss), 6'b0, 12'(cnt)};
  endfunction

  function automatic logic [31:0] mk_cfg(bit en, int sp, int dp, int fl, bit halt);
    return {13'b0, halt, 4'b0, 3'(fl), 5'(dp), 5'(sp), en};
  endfunction

  task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] l,
                       input logic [31:0] c, input logic [31:0] f);
    wr(3'd0, s); wr(3'd1, d); wr(3'd2, l); wr(3'd3, c); wr(3'd4, f);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] c;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state idle
    chk("R1 reset busy", busy, 0);
    chk("R1 reset mem_req", mem_req, 0);
    chk("R1 reset tc", tc_pulse, 0);
    chk("R1 reset cfg", cfg_q, 0);

    // R11: global enable low ignores kick
    setup(32'h0, 32'h100, 0, mk_ctl(2, 2, 2, 1, 1, 0), mk_cfg(1, 0, 0, 0, 0));
    nlog = 0;
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0; chk("R11 busy", busy, 0);
    repeat (5) @(negedge clk);
    chk("R11 no access", nlog, 0);
    chk("R11 count kept", ctl_q[11:0], 2);
    glb_en = 1'b1;

    // R4 R5 R6 R7 R9: basic three element copy
    setup(32'h0, 32'h100, 0, mk_ctl(3, 2, 2, 1, 1, 1), mk_cfg(1, 0, 0, 0, 0));
    run();
    chk("R6 accesses", nlog, 6);
    for (int i = 0; i < 3; i++) begin
      chk("R4 data", mem[8'h40 + i], mem[i]);
      chk("R4 read addr", lg_addr[2*i], 4*i);
      chk("R4 write flag", lg_we[2*i+1], 1);
      chk("R4 write addr", lg_addr[2*i+1], 32'h100 + 4*i);
      chk("R4 size", lg_size[2*i], 2);
    end
    chk("R5 src", src_q, 32'h0C);
    chk("R5 dst", dst_q, 32'h10C);
    chk("R4 ctl", ctl_q, mk_ctl(0, 2, 2, 1, 1, 1));
    chk("R7 cfg", cfg_q, 32'h0);
    chk("R9 tc", tc_cnt, 1);

    // R1: halt and disabled
    setup(32'h0, 32'h100, 0, mk_ctl(2, 2, 2, 1, 1, 1), mk_cfg(1, 0, 0, 0, 1));
    run();
    chk("R1 halt no access", nlog, 0);
    chk("R1 halt count", ctl_q[11:0], 2);
    wr(3'd4, mk_cfg(0, 0, 0, 0, 0));
    run();
    chk("R1 disabled no access", nlog, 0);
    chk("R1 disabled src", src_q, 0);

    // R3: count zero
    setup(32'h0, 32'h100, 0, mk_ctl(0, 2, 2, 1, 1, 1), mk_cfg(1, 0, 0, 0, 0));
    run();
    chk("R3 no access", nlog, 0);
    chk("R3 enable kept", cfg_q[0], 1);
    chk("R3 tc", tc_cnt, 0);

    // R2: flow modes, source request on single, destination on burst
    for (int m = 0; m < 8; m++) begin
      for (int p = 0; p < 4; p++) begin
        bit ex;
        req_single = p[0] ? (32'h1 << 5) : 32'h0;
        req_burst  = p[1] ? (32'h1 << 9) : 32'h0;
        case (m)
          0: ex = 1;
          1: ex = p[1];
          2: ex = p[0];
          3: ex = p[0] & p[1];
          default: ex = 0;
        endcase
        setup(32'h10, 32'h140, 0, mk_ctl(1, 2, 2, 1, 1, 0), mk_cfg(1, 5, 9, m, 0));
        run();
        chk($sformatf("R2 mode%0d pat%0d", m, p), nlog, ex ? 2 : 0);
      end
    end
    req_single = '0; req_burst = '0;

    // R5: mixed widths
    setup(32'h20, 32'h180, 0, mk_ctl(4, 0, 1, 1, 1, 0), mk_cfg(1, 0, 0, 0, 0));
    run();
    chk("R5 byte src", src_q, 32'h24);
    chk("R5 half dst", dst_q, 32'h188);
    chk("R4 read size", lg_size[0], 0);
    chk("R4 write size", lg_size[1], 1);

    // R5: no increment
    setup(32'h30, 32'h1C0, 0, mk_ctl(3, 2, 2, 0, 0, 0), mk_cfg(1, 0, 0, 0, 0));
    run();
    chk("R5 fixed src", src_q, 32'h30);
    chk("R5 fixed dst", dst_q, 32'h1C0);
    chk("R5 fixed last read", lg_addr[4], 32'h30);

    // R8 R9: descriptor chain, first control asks for tc, loaded one does not
    mem[8'h80] = 32'h40;
    mem[8'h81] = 32'h1A0;
    mem[8'h82] = 32'h0;
    mem[8'h83] = mk_ctl(2, 2, 2, 1, 1, 0);
    setup(32'h0, 32'h100, 32'h200, mk_ctl(1, 2, 2, 1, 1, 1), mk_cfg(1, 0, 0, 0, 0));
    run();
    chk("R8 accesses", nlog, 10);
    chk("R8 fetch0", lg_addr[2], 32'h200);
    chk("R8 fetch1", lg_addr[3], 32'h204);
    chk("R8 fetch2", lg_addr[4], 32'h20C);
    chk("R8 fetch3", lg_addr[5], 32'h208);
    chk("R8 fetch size", lg_size[5], 2);
    chk("R8 new read", lg_addr[6], 32'h40);
    chk("R8 new write", lg_addr[9], 32'h1A4);
    chk("R8 link", link_q, 0);
    chk("R8 ctl", ctl_q, mk_ctl(0, 2, 2, 1, 1, 0));
    chk("R7 cfg after chain", cfg_q[0], 0);
    chk("R9 tc from new ctl", tc_cnt, 0);

    // R9: chain where loaded control asks for tc
    mem[8'h83] = mk_ctl(1, 2, 2, 1, 1, 1);
    setup(32'h0, 32'h100, 32'h200, mk_ctl(1, 2, 2, 1, 1, 0), mk_cfg(1, 0, 0, 0, 0));
    run();
    chk("R9 tc twice", tc_cnt, 2);

    // R4 R5 R6 R10: random descriptors with random ready delays
    for (int it = 0; it < 20; it++) begin
      int cn = 1 + ($urandom % 5);
      int ss = $urandom % 3;
      int ds = $urandom % 3;
      bit si = $urandom % 2;
      bit di = $urandom % 2;
      bit ie = $urandom % 2;
      logic [31:0] s0 = ($urandom % 32) * 4;
      logic [31:0] d0 = 32'h100 + ($urandom % 32) * 4;
      c = mk_ctl(cn, ss, ds, si, di, ie);
      setup(s0, d0, 0, c, mk_cfg(1, 0, 0, 0, 0));
      run();
      chk("R6 random accesses", nlog, 2 * cn);
      chk("R5 random src", src_q, s0 + (si ? cn * (1 << ss) : 0));
      chk("R5 random dst", dst_q, d0 + (di ? cn * (1 << ds) : 0));
      chk("R4 random ctl", ctl_q, c & 32'hFFFF_F000);
      chk("R9 random tc", tc_cnt, ie);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule